// File: doc/BRIEF.md
# Remote Transfer Packet Segmenter

This block accepts one transfer command and breaks it into a stream of packet descriptors for a RapidIO-style request path. A command carries a request kind (NREAD, NWRITE or SWRITE), a remote byte address, a byte count and a local byte address. Before it emits anything, the block checks the command against the lane-placement rules of the link. A command that breaks them is rejected with a one-cycle error pulse and produces no descriptors.

A legal command is cut into at most three kinds of pieces, always in the same order. The first is an optional leading piece that covers the upper lanes of the first doubleword. Next come whole-doubleword pieces of at most 256 bytes each. The last is an optional trailing piece that starts at lane 0.

Every descriptor carries a remote address rounded down to a doubleword, the first byte lane, the byte count, a whole-doubleword flag, the matching local address and a last flag. Descriptors leave one per valid/ready handshake.

The control is a five-state machine:
- **SEG_IDLE** waits for a command.
- **SEG_REJECT** lasts one cycle and drives the error pulse.
- **SEG_LEAD** presents the leading partial piece.
- **SEG_BODY** presents whole-doubleword pieces.
- **SEG_TAIL** presents the trailing partial piece.

The transitions are as follows:
- *accept* goes from SEG_IDLE or SEG_REJECT to the state that fits the command.
- *drop* goes from SEG_REJECT back to SEG_IDLE.
- *advance* goes from a segment state to SEG_BODY, SEG_TAIL or SEG_IDLE on each handshake, chosen by the bytes that remain.

Top module: `rio_req_segmenter`

## Requirements
- R1: After reset `busy`, `pkt_valid` and `cmd_err` are low. A legal command is sampled on a clock edge where `cmd_valid` is high while the block is not busy. The first descriptor and `busy` are visible from the next cycle on. `busy` stays high until the handshake of the descriptor flagged `pkt_last`.
- R2: A command is illegal when its byte count is zero or its kind code is 3. Kind codes are 0 = NREAD, 1 = NWRITE, 2 = SWRITE. An illegal command raises `cmd_err` for exactly one cycle, the cycle after it is sampled, and no descriptor is emitted.
- R3: An SWRITE is legal only if remote address bits [2:0] are 000 and the byte count is a multiple of 8. Each of its descriptors has `pkt_whole` = 1.
- R4: For NREAD and NWRITE, let o be remote address bits [2:0] and L the byte count. o = 0 and o = 7 accept any L. o = 1 accepts L = 1 or L >= 7. o = 2 accepts L <= 2 or L >= 6. o = 3 accepts L = 1 or L >= 5. o = 4 accepts L <= 2 or L >= 4. o = 5 accepts L = 1 or L >= 3. o = 6 accepts any L >= 1. Every other pairing is rejected as in R2.
- R5: The local address is never checked and may hold any byte value, for every kind.
- R6: Every descriptor has `pkt_rem_addr` bits [2:0] = 000. `pkt_first_lane` gives the first byte lane inside that doubleword, and `pkt_bytes` gives the byte count. `pkt_kind` repeats the command kind.
- R7: Descriptor order is fixed:
  - If o != 0, the first descriptor covers lanes o up to min(7, o+L-1).
  - Then come whole-doubleword descriptors (`pkt_whole` = 1, lane 0), each of min(remaining rounded down to 8, 256) bytes.
  - Then, if fewer than 8 bytes remain, one trailing descriptor at lane 0 carries the rest.
- R8: From each descriptor to the next, both the remote byte position and `pkt_loc_addr` advance by exactly the previous `pkt_bytes`.
- R9: While `pkt_valid` is high and `pkt_ready` is low, every descriptor field holds its value.
- R10: A `cmd_valid` pulse while `busy` is high is ignored, and the descriptor stream of the running command is unchanged.
- R11: Packet counts follow the segmentation, and only the final descriptor has `pkt_last` = 1:
  - 3 bytes at o = 0 or o = 5 give one descriptor.
  - 3 bytes at o = 6 or o = 7 give two.
  - 8 bytes at o = 4 give two.
  - 4 bytes at o = 4 give one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_kind | input | 2 | Request kind: 0 NREAD, 1 NWRITE, 2 SWRITE, 3 invalid |
| cmd_rem_addr | input | AW | Remote byte address |
| cmd_len | input | LW | Byte count |
| cmd_loc_addr | input | AW | Local byte address |
| busy | output | 1 | Command in progress |
| cmd_err | output | 1 | One-cycle rejection pulse |
| pkt_valid | output | 1 | Descriptor present |
| pkt_ready | input | 1 | Descriptor taken when high with pkt_valid |
| pkt_kind | output | 2 | Kind of the current command |
| pkt_rem_addr | output | AW | Doubleword-aligned remote address |
| pkt_loc_addr | output | AW | Local address of the first byte |
| pkt_whole | output | 1 | Piece is made of whole doublewords |
| pkt_first_lane | output | 3 | First byte lane within the doubleword |
| pkt_bytes | output | BW | Bytes in this piece (BW = log2(MAXB)+1) |
| pkt_last | output | 1 | Final descriptor of the command |

## Verification
A wrong state-machine state shows up at the ports in the first cycle after accept or after a handshake. Either `pkt_whole` or `pkt_first_lane` takes the wrong value, or `busy` stays up or drops one descriptor too soon, so the descriptor count and the `pkt_last` position differ. A wrong remaining-byte count or address register shows up in the next descriptor's `pkt_bytes` or `pkt_loc_addr`. That error then carries through the rest of the stream. A legality fault is seen one cycle after the command, as a missing or spurious `cmd_err` pulse, so the offset and count tables are swept at each offset where the legal set changes.

// File: rtl/rio_seg_pkg.sv
package rio_seg_pkg;

    typedef enum logic [1:0] {
        RQ_NREAD  = 2'd0,
        RQ_NWRITE = 2'd1,
        RQ_SWRITE = 2'd2,
        RQ_BAD    = 2'd3
    } rq_kind_e;

    typedef enum logic [2:0] {
        SEG_IDLE,
        SEG_REJECT,
        SEG_LEAD,
        SEG_BODY,
        SEG_TAIL
    } seg_state_e;

    // Legal placement of n bytes inside one doubleword starting at lane s.
    function automatic logic lane_ok(input logic [2:0] s, input logic [3:0] n);
        logic ends_top;
        ends_top = ({1'b0, s} + n) == 4'd8;
        unique case (n)
            4'd1:                      lane_ok = 1'b1;
            4'd2:                      lane_ok = (s[0] == 1'b0);
            4'd4:                      lane_ok = (s == 3'd0) || (s == 3'd4);
            4'd3, 4'd5, 4'd6, 4'd7:    lane_ok = (s == 3'd0) || ends_top;
            4'd8:                      lane_ok = (s == 3'd0);
            default:                   lane_ok = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rio_seg_check.sv
module rio_seg_check
    import rio_seg_pkg::*;
#(
    parameter int LW = 16
) (
    input  rq_kind_e        kind,
    input  logic [2:0]      off,
    input  logic [LW-1:0]   len,
    output logic            legal
);

    logic [LW-1:0] lead_room;
    logic          reaches_top;

    assign lead_room   = LW'(4'd8 - {1'b0, off});
    assign reaches_top = (len >= lead_room);

    always_comb begin
        legal = 1'b0;
        if (len != '0) begin
            unique case (kind)
                RQ_SWRITE: legal = (off == 3'd0) && (len[2:0] == 3'd0);
                RQ_NREAD,
                RQ_NWRITE: begin
                    if (off == 3'd0 || reaches_top)
                        legal = 1'b1;
                    else
                        legal = lane_ok(off, {1'b0, len[2:0]});
                end
                default:   legal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/rio_seg_sizer.sv
module rio_seg_sizer
    import rio_seg_pkg::*;
#(
    parameter int LW   = 16,
    parameter int MAXB = 256
) (
    input  seg_state_e      state,
    input  logic [2:0]      off,
    input  logic [LW-1:0]   remain,
    output logic [LW-1:0]   size
);

    localparam logic [LW-1:0] CAP = LW'(MAXB);

    logic [LW-1:0] room;
    logic [LW-1:0] bulk;

    assign room = LW'(4'd8 - {1'b0, off});
    assign bulk = {remain[LW-1:3], 3'b000};

    always_comb begin
        unique case (state)
            SEG_LEAD: size = (remain < room) ? remain : room;
            SEG_BODY: size = (bulk > CAP) ? CAP : bulk;
            SEG_TAIL: size = remain;
            default:  size = '0;
        endcase
    end

endmodule

// File: rtl/rio_req_segmenter.sv
module rio_req_segmenter
    import rio_seg_pkg::*;
#(
    parameter int AW   = 32,
    parameter int LW   = 16,
    parameter int MAXB = 256,
    localparam int BW  = $clog2(MAXB) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_kind,
    input  logic [AW-1:0]   cmd_rem_addr,
    input  logic [LW-1:0]   cmd_len,
    input  logic [AW-1:0]   cmd_loc_addr,
    output logic            busy,
    output logic            cmd_err,
    output logic            pkt_valid,
    input  logic            pkt_ready,
    output logic [1:0]      pkt_kind,
    output logic [AW-1:0]   pkt_rem_addr,
    output logic [AW-1:0]   pkt_loc_addr,
    output logic            pkt_whole,
    output logic [2:0]      pkt_first_lane,
    output logic [BW-1:0]   pkt_bytes,
    output logic            pkt_last
);

    seg_state_e    state, state_nx, entry_state;
    logic [AW-1:0] cur_rem, cur_loc;
    logic [LW-1:0] remain, size_w, rem_after;
    rq_kind_e      kind_q;
    logic          legal, accept, take;

    rio_seg_check #(.LW(LW)) u_check (
        .kind  (rq_kind_e'(cmd_kind)),
        .off   (cmd_rem_addr[2:0]),
        .len   (cmd_len),
        .legal (legal)
    );

    rio_seg_sizer #(.LW(LW), .MAXB(MAXB)) u_sizer (
        .state  (state),
        .off    (cur_rem[2:0]),
        .remain (remain),
        .size   (size_w)
    );

    assign accept    = cmd_valid && (state == SEG_IDLE || state == SEG_REJECT);
    assign take      = pkt_valid && pkt_ready;
    assign rem_after = remain - size_w;

    always_comb begin
        if (!legal)
            entry_state = SEG_REJECT;
        else if (cmd_rem_addr[2:0] != 3'd0)
            entry_state = SEG_LEAD;
        else if (cmd_len >= LW'(8))
            entry_state = SEG_BODY;
        else
            entry_state = SEG_TAIL;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEG_IDLE, SEG_REJECT: state_nx = accept ? entry_state : SEG_IDLE;
            SEG_LEAD, SEG_BODY, SEG_TAIL: begin
                if (take) begin
                    if (rem_after == '0)
                        state_nx = SEG_IDLE;
                    else if (rem_after >= LW'(8))
                        state_nx = SEG_BODY;
                    else
                        state_nx = SEG_TAIL;
                end
            end
            default: state_nx = SEG_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SEG_IDLE;
        else
            state <= state_nx;
    end

    // Command tracking registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_rem <= '0;
            cur_loc <= '0;
            remain  <= '0;
            kind_q  <= RQ_NREAD;
        end else if (accept) begin
            cur_rem <= cmd_rem_addr;
            cur_loc <= cmd_loc_addr;
            remain  <= cmd_len;
            kind_q  <= rq_kind_e'(cmd_kind);
        end else if (take) begin
            cur_rem <= cur_rem + AW'(size_w);
            cur_loc <= cur_loc + AW'(size_w);
            remain  <= rem_after;
        end
    end

    // Outputs
    always_comb begin
        pkt_valid      = (state == SEG_LEAD) || (state == SEG_BODY) || (state == SEG_TAIL);
        busy           = pkt_valid;
        cmd_err        = (state == SEG_REJECT);
        pkt_kind       = kind_q;
        pkt_rem_addr   = {cur_rem[AW-1:3], 3'b000};
        pkt_loc_addr   = cur_loc;
        pkt_whole      = (state == SEG_BODY);
        pkt_first_lane = cur_rem[2:0];
        pkt_bytes      = size_w[BW-1:0];
        pkt_last       = pkt_valid && (rem_after == '0);
    end

    // ---------------- assertions ----------------
    p_err_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> !cmd_err);

    p_err_no_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !pkt_valid);

    p_swrite_whole_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_kind == RQ_SWRITE) |-> pkt_whole);

    p_lane_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_whole) |->
            (pkt_bytes <= BW'(8)) && lane_ok(pkt_first_lane, pkt_bytes[3:0]));

    p_body_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_whole) |->
            (pkt_bytes[2:0] == 3'd0) && (pkt_bytes != '0) && (pkt_bytes <= BW'(MAXB))
            && (pkt_first_lane == 3'd0));

    p_loc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && !pkt_last) |=>
            pkt_valid && (pkt_loc_addr == $past(pkt_loc_addr) + AW'($past(pkt_bytes))));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=>
            pkt_valid && $stable(pkt_rem_addr) && $stable(pkt_loc_addr)
            && $stable(pkt_bytes) && $stable(pkt_first_lane) && $stable(pkt_last));

    p_busy_until_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(pkt_ready && pkt_last)) |=> busy);

endmodule

// File: tb/rio_req_segmenter_tb.sv
`timescale 1ns/1ps
module rio_req_segmenter_tb;

    localparam int AW = 32;
    localparam int LW = 16;
    localparam int BW = 9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [1:0]      cmd_kind = '0;
    logic [AW-1:0]   cmd_rem_addr = '0;
    logic [LW-1:0]   cmd_len = '0;
    logic [AW-1:0]   cmd_loc_addr = '0;
    logic            busy, cmd_err, pkt_valid, pkt_whole, pkt_last;
    logic            pkt_ready = 1'b0;
    logic [1:0]      pkt_kind;
    logic [AW-1:0]   pkt_rem_addr, pkt_loc_addr;
    logic [2:0]      pkt_first_lane;
    logic [BW-1:0]   pkt_bytes;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rio_req_segmenter u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_rem_addr(cmd_rem_addr), .cmd_len(cmd_len), .cmd_loc_addr(cmd_loc_addr),
        .busy(busy), .cmd_err(cmd_err), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_kind(pkt_kind), .pkt_rem_addr(pkt_rem_addr), .pkt_loc_addr(pkt_loc_addr),
        .pkt_whole(pkt_whole), .pkt_first_lane(pkt_first_lane), .pkt_bytes(pkt_bytes),
        .pkt_last(pkt_last)
    );

    // expected descriptor list
    longint e_rem [64];
    longint e_loc [64];
    int     e_bytes [64];
    int     e_lane [64];
    int     e_whole [64];
    int     e_n;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit legal_tb(input int kind, input longint rem, input int len);
        int o;
        o = int'(rem % 8);
        if (len == 0 || kind == 3) return 0;
        if (kind == 2) return (o == 0) && (len % 8 == 0);
        case (o)
            1: return (len == 1) || (len >= 7);
            2: return (len <= 2) || (len >= 6);
            3: return (len == 1) || (len >= 5);
            4: return (len <= 2) || (len >= 4);
            5: return (len == 1) || (len >= 3);
            default: return 1;
        endcase
    endfunction

    task automatic build_exp(input longint rem, input int len, input longint loc);
        longint a = rem;
        longint l = loc;
        int r = len;
        e_n = 0;
        while (r > 0 && e_n < 64) begin
            int o = int'(a % 8);
            int sz;
            if (o != 0) begin
                sz = (r < 8 - o) ? r : 8 - o;
                e_whole[e_n] = 0; e_lane[e_n] = o;
            end else if (r >= 8) begin
                sz = (r / 8) * 8;
                if (sz > 256) sz = 256;
                e_whole[e_n] = 1; e_lane[e_n] = 0;
            end else begin
                sz = r;
                e_whole[e_n] = 0; e_lane[e_n] = 0;
            end
            e_rem[e_n] = a - (a % 8);
            e_loc[e_n] = l;
            e_bytes[e_n] = sz;
            a += sz; l += sz; r -= sz; e_n++;
        end
    endtask

    // Issue a command and follow its outcome. stall=1 withholds ready two cycles in three.
    task automatic run_cmd(input string req, input int kind, input longint rem, input int len,
                           input longint loc, input bit stall, input bit intrude);
        bit lg;
        int idx = 0;
        int cyc = 0;
        lg = legal_tb(kind, rem, len);
        if (lg) build_exp(rem, len, loc); else e_n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'(kind); cmd_rem_addr = AW'(rem);
        cmd_len = LW'(len); cmd_loc_addr = AW'(loc);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!lg) begin
            chk(req, "cmd_err on reject", longint'(cmd_err), 1);
            chk(req, "pkt_valid on reject", longint'(pkt_valid), 0);
            @(negedge clk);
            chk(req, "cmd_err one cycle", longint'(cmd_err), 0);
            chk(req, "no descriptor after reject", longint'(pkt_valid), 0);
            return;
        end
        chk("R1", "busy after accept", longint'(busy), 1);
        chk(req, "cmd_err on legal", longint'(cmd_err), 0);
        while (busy && cyc < 3000) begin
            if (intrude && cyc == 1) begin
                cmd_valid = 1'b1; cmd_kind = 2'd2; cmd_rem_addr = 32'h0000_0100;
                cmd_len = LW'(64); cmd_loc_addr = 32'h0000_0400;
            end else begin
                cmd_valid = 1'b0;
            end
            pkt_ready = !stall || (cyc % 3 == 2);
            if (pkt_valid) begin
                if (idx < e_n) begin
                    chk(req, "pkt_rem_addr", longint'(pkt_rem_addr), e_rem[idx]);
                    chk("R8", "pkt_loc_addr", longint'(pkt_loc_addr), e_loc[idx]);
                    chk(req, "pkt_bytes", longint'(pkt_bytes), longint'(e_bytes[idx]));
                    chk("R6", "pkt_first_lane", longint'(pkt_first_lane), longint'(e_lane[idx]));
                    chk("R7", "pkt_whole", longint'(pkt_whole), longint'(e_whole[idx]));
                    chk("R6", "pkt_kind", longint'(pkt_kind), longint'(kind));
                    chk("R11", "pkt_last", longint'(pkt_last), longint'(idx == e_n - 1));
                end else begin
                    chk(req, "extra descriptor", longint'(idx), longint'(e_n - 1));
                end
                if (pkt_ready) idx++;
            end
            @(negedge clk);
            cyc++;
        end
        cmd_valid = 1'b0;
        pkt_ready = 1'b0;
        chk("R11", "descriptor count", longint'(idx), longint'(e_n));
        chk("R1", "busy low after last", longint'(busy), 0);
    endtask

    task automatic t_reset();
        chk("R1", "busy at reset", longint'(busy), 0);
        chk("R1", "pkt_valid at reset", longint'(pkt_valid), 0);
        chk("R1", "cmd_err at reset", longint'(cmd_err), 0);
    endtask

    task automatic t_short_counts();
        run_cmd("R11", 1, 64'h1000_0000, 3, 64'h2000_0001, 0, 0); // one
        run_cmd("R11", 1, 64'h1000_0005, 3, 64'h2000_0002, 0, 0); // one
        run_cmd("R11", 0, 64'h1000_0006, 3, 64'h2000_0003, 0, 0); // two
        run_cmd("R11", 1, 64'h1000_0007, 3, 64'h2000_0004, 0, 0); // two
        run_cmd("R11", 0, 64'h1080_0004, 8, 64'h1180_0004, 0, 0); // two
        run_cmd("R11", 1, 64'h1080_0004, 4, 64'h1180_0004, 0, 0); // one
    endtask

    task automatic t_table();
        // NREAD/NWRITE legality around each offset's boundary
        for (int o = 1; o < 8; o++) begin
            for (int l = 1; l <= 8; l++) begin
                run_cmd("R4", (o % 2), 64'h0000_3000 + longint'(o), l, 64'h0000_5003, 0, 0);
            end
        end
    endtask

    task automatic t_illegal();
        run_cmd("R2", 1, 64'h40, 0, 64'h80, 0, 0);
        run_cmd("R2", 3, 64'h40, 16, 64'h80, 0, 0);
        run_cmd("R3", 2, 64'h44, 16, 64'h80, 0, 0);
        run_cmd("R3", 2, 64'h40, 12, 64'h80, 0, 0);
    endtask

    task automatic t_swrite();
        run_cmd("R3", 2, 64'h0001_0000, 520, 64'h0002_0007, 0, 0);
        run_cmd("R5", 2, 64'h0001_0008, 8, 64'h0002_0003, 0, 0);
    endtask

    task automatic t_long();
        run_cmd("R7", 0, 64'h0003_0003, 600, 64'h0009_0001, 0, 0);
        run_cmd("R7", 1, 64'h0003_0000, 263, 64'h0009_0000, 0, 0);
    endtask

    task automatic t_stall();
        run_cmd("R9", 1, 64'h0004_0002, 531, 64'h000A_0005, 1, 0);
    endtask

    task automatic t_busy_ignore();
        run_cmd("R10", 0, 64'h0005_0001, 300, 64'h000B_0006, 1, 1);
        // a stray pulse must not have started anything new
        @(negedge clk);
        chk("R10", "idle after ignored pulse", longint'(busy), 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_counts();
        t_illegal();
        t_swrite();
        t_long();
        t_stall();
        t_busy_ignore();
        t_table();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule